// File: doc/BRIEF.md
# Scan Chain Splicer with Four Downstream Ports

This block is a test-access slave on a primary serial test bus that follows IEEE 1149.1. It lets a board-level scan chain grow by any mix of four downstream scan chains. The block keeps its own TAP state machine and an instruction register. In front of the downstream chains it places one of three data registers: a one-bit bypass cell, a four-bit path-select register and a four-bit identification register.

The block's own register always sits nearest the serial input. After it come the downstream chains that the select register enables, from port 0 up to port 3. The downstream chains are part of the path in instruction shifts as well as in data shifts. Port 0 is the first of the four ports in the chain. The identification register samples a 4-bit input bus, so software can tell which board position it is scanning.

A new selection takes effect only when the TAP passes through Update-DR. The chain length therefore never changes while bits are shifting. A hold of the reset pin, or five test clocks with mode high, returns the block to its reset state.

Top module: `scan_path_linker`

## Requirements
- R1: The TAP state machine moves through the sixteen IEEE 1149.1 states on each rising edge of tck, under control of tms. This includes the Pause-DR and Exit2-DR detour back into Shift-DR.
- R2: A low trst_n, or five rising tck edges with tms high, puts the TAP in Test-Logic-Reset. In that state no downstream port is selected and the instruction is bypass, code 3'b111. After trst_n rises, the TAP stays in Test-Logic-Reset for the first two rising edges.
- R3: The instruction register is 3 bits. It loads 3'b001 in Capture-IR and shifts with tdi entering the MSB and bit 0 leaving first. It takes the shifted value in Update-IR. Code 3'b010 selects the path-select register and 3'b011 selects the identification register. Every other code selects bypass.
- R4: The bypass register is one bit. It loads 0 in Capture-DR and delays tdi by one shift.
- R5: The path-select register is 4 bits, and bit i enables downstream port i. It loads the current selection in Capture-DR and shifts with bit 0 leaving first. It changes the active selection only in Update-DR.
- R6: The serial path runs tdi, then the block's own register, then each enabled port in ascending order, then tdo. Each dn_tdi[i] carries the output of the stage in front of port i.
- R7: Any of the sixteen selection values is allowed, from no port to all four.
- R8: In Capture-DR, the identification register loads id_bus, and bit 0 leaves first.
- R9: tdo changes on the falling edge of tck. tdo_oe is high only in the half-cycles that follow a falling edge in Shift-IR or Shift-DR.
- R10: dn_tck copies tck. dn_tms[i] copies tms while port i is selected and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Primary serial input |
| tdo | output | 1 | Primary serial output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high only while shifting |
| id_bus | input | 4 | Identification value sampled in Capture-DR |
| dn_tck | output | 1 | Clock to the downstream chains |
| dn_tms | output | 4 | Mode select to each downstream chain |
| dn_tdi | output | 4 | Serial data into each downstream chain |
| dn_tdo | input | 4 | Serial data back from each downstream chain |

## Verification
A wrong TAP state shows up within one falling edge, because tdo_oe rises or falls at the wrong time. A corrupted selection shows up at once, in two ways: dn_tms gates the wrong ports, and the dn_tdi links take the wrong shape. A fault in an instruction, bypass, select or identification bit comes out on tdo after the number of shifts that separates that bit from the output. The bench models the downstream chains as lengths one to four and predicts the whole spliced stream. Every bit that reaches tdo is therefore compared against a reference of the correct length.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_SELECT  = 3'b010;
  localparam logic [IR_W-1:0] OP_IDENT   = 3'b011;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/slk_reset_sync.sv
module slk_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/slk_tap_fsm.sv
module slk_tap_fsm
  import scan_link_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st
);
  tap_state_e st_d;

  always_comb begin
    unique case (st)
      ST_TLR:    st_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_TLR;
    else        st <= st_d;
  end
endmodule

// File: rtl/slk_regs.sv
module slk_regs
  import scan_link_pkg::*;
#(
  parameter int N_PATHS = 4,
  parameter int ID_W    = 4
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         st,
  input  logic               tdi,
  input  logic [ID_W-1:0]    id_bus,
  output logic               own_so,
  output logic [N_PATHS-1:0] sel_q,
  output logic [IR_W-1:0]    ir_q,
  output logic [ID_W-1:0]    id_sr_q
);
  logic [IR_W-1:0]    ir_sr_q, ir_sr_d, ir_d;
  logic [N_PATHS-1:0] sel_sr_q, sel_sr_d, sel_d;
  logic [ID_W-1:0]    id_sr_d;
  logic               byp_q, byp_d;
  logic               ir_sr_en, ir_en, sel_sr_en, sel_en, id_sr_en, byp_en;
  logic               dr_cap, dr_sh, pick_sel, pick_id;

  always_comb begin
    dr_cap   = (st == ST_CAP_DR);
    dr_sh    = (st == ST_SH_DR);
    pick_sel = (ir_q == OP_SELECT);
    pick_id  = (ir_q == OP_IDENT);

    ir_sr_en = (st == ST_CAP_IR) || (st == ST_SH_IR);
    ir_sr_d  = (st == ST_CAP_IR) ? IR_CAPTURE : {tdi, ir_sr_q[IR_W-1:1]};
    ir_en    = (st == ST_UPD_IR) || (st == ST_TLR);
    ir_d     = (st == ST_TLR) ? OP_BYPASS : ir_sr_q;

    sel_sr_en = pick_sel && (dr_cap || dr_sh);
    sel_sr_d  = dr_cap ? sel_q : {tdi, sel_sr_q[N_PATHS-1:1]};
    sel_en    = (st == ST_TLR) || ((st == ST_UPD_DR) && pick_sel);
    sel_d     = (st == ST_TLR) ? '0 : sel_sr_q;

    id_sr_en = pick_id && (dr_cap || dr_sh);
    id_sr_d  = dr_cap ? id_bus : {tdi, id_sr_q[ID_W-1:1]};

    byp_en = !pick_sel && !pick_id && (dr_cap || dr_sh);
    byp_d  = dr_sh & tdi;

    own_so = 1'b0;
    if (st == ST_SH_IR)  own_so = ir_sr_q[0];
    else if (dr_sh)      own_so = pick_sel ? sel_sr_q[0] : (pick_id ? id_sr_q[0] : byp_q);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr_q  <= '0;
      ir_q     <= OP_BYPASS;
      sel_sr_q <= '0;
      sel_q    <= '0;
      id_sr_q  <= '0;
      byp_q    <= 1'b0;
    end else begin
      if (ir_sr_en)  ir_sr_q  <= ir_sr_d;
      if (ir_en)     ir_q     <= ir_d;
      if (sel_sr_en) sel_sr_q <= sel_sr_d;
      if (sel_en)    sel_q    <= sel_d;
      if (id_sr_en)  id_sr_q  <= id_sr_d;
      if (byp_en)    byp_q    <= byp_d;
    end
  end
endmodule

// File: rtl/slk_chain.sv
module slk_chain #(
  parameter int N_PATHS = 4
) (
  input  logic               own_so,
  input  logic               tms,
  input  logic [N_PATHS-1:0] sel,
  input  logic [N_PATHS-1:0] dn_tdo,
  output logic [N_PATHS-1:0] dn_tdi,
  output logic [N_PATHS-1:0] dn_tms,
  output logic               chain_so
);
  logic [N_PATHS:0] link;

  assign link[0] = own_so;

  for (genvar i = 0; i < N_PATHS; i++) begin : g_path
    assign dn_tdi[i]  = link[i];
    assign link[i+1]  = sel[i] ? dn_tdo[i] : link[i];
    assign dn_tms[i]  = sel[i] & tms;
  end

  assign chain_so = link[N_PATHS];
endmodule

// File: rtl/scan_path_linker.sv
module scan_path_linker
  import scan_link_pkg::*;
#(
  parameter int N_PATHS = 4,
  parameter int ID_W    = 4
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [ID_W-1:0]    id_bus,
  output logic               dn_tck,
  output logic [N_PATHS-1:0] dn_tms,
  output logic [N_PATHS-1:0] dn_tdi,
  input  logic [N_PATHS-1:0] dn_tdo
);
  localparam int SYNC_STAGES = 2;

  logic               rst_n;
  tap_state_e         st;
  logic               own_so, chain_so, shifting;
  logic [N_PATHS-1:0] sel_q;
  logic [IR_W-1:0]    ir_q;
  logic [ID_W-1:0]    id_sr_q;

  slk_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .tck(tck), .trst_n(trst_n), .rst_n(rst_n)
  );

  slk_tap_fsm u_tap (
    .tck(tck), .rst_n(rst_n), .tms(tms), .st(st)
  );

  slk_regs #(.N_PATHS(N_PATHS), .ID_W(ID_W)) u_regs (
    .tck(tck), .rst_n(rst_n), .st(st), .tdi(tdi), .id_bus(id_bus),
    .own_so(own_so), .sel_q(sel_q), .ir_q(ir_q), .id_sr_q(id_sr_q)
  );

  slk_chain #(.N_PATHS(N_PATHS)) u_chain (
    .own_so(own_so), .tms(tms), .sel(sel_q), .dn_tdo(dn_tdo),
    .dn_tdi(dn_tdi), .dn_tms(dn_tms), .chain_so(chain_so)
  );

  assign dn_tck   = tck;
  assign shifting = (st == ST_SH_DR) || (st == ST_SH_IR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      if (shifting) tdo <= chain_so;
    end
  end
endmodule

// File: rtl/slk_checker.sv
module slk_checker
  import scan_link_pkg::*;
#(
  parameter int N_PATHS = 4,
  parameter int ID_W    = 4
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input tap_state_e         st,
  input logic [IR_W-1:0]    ir_q,
  input logic [N_PATHS-1:0] sel_q,
  input logic [ID_W-1:0]    id_sr_q,
  input logic [ID_W-1:0]    id_bus,
  input logic               tdo_oe
);
  AST_TLR_CLEARS_SEL: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_TLR) |=> (sel_q == '0)); // R2

  AST_TLR_IR_BYPASS: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_TLR) |=> (ir_q == OP_BYPASS)); // R2

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == ST_TLR)); // R2

  AST_SEL_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    ((st != ST_UPD_DR) && (st != ST_TLR)) |=> $stable(sel_q)); // R5

  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    ((st == ST_CAP_DR) && (ir_q == OP_IDENT)) |=> (id_sr_q == $past(id_bus))); // R8

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((st == ST_SH_DR) || (st == ST_SH_IR))); // R9
endmodule

bind scan_path_linker slk_checker #(.N_PATHS(N_PATHS), .ID_W(ID_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .st(st), .ir_q(ir_q),
  .sel_q(sel_q), .id_sr_q(id_sr_q), .id_bus(id_bus), .tdo_oe(tdo_oe)
);

// File: tb/tb_scan_path_linker.sv
`timescale 1ns/1ps
module tb_scan_path_linker;
  import scan_link_pkg::*;

  logic       tck = 1'b0;
  logic       trst_n = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [3:0] id_bus = 4'h0;
  logic       tdo, tdo_oe, dn_tck;
  logic [3:0] dn_tms, dn_tdi, dn_tdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 tck = ~tck;

  scan_path_linker dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .id_bus(id_bus), .dn_tck(dn_tck), .dn_tms(dn_tms), .dn_tdi(dn_tdi), .dn_tdo(dn_tdo)
  );

  // Downstream chains of lengths 1..4, shifting on every dn_tck rise
  logic [15:0] dch = '0;
  always @(posedge dn_tck) begin
    for (int i = 0; i < 4; i++) dch[4*i +: 4] <= {dch[4*i +: 3], dn_tdi[i]};
  end
  always_comb begin
    for (int i = 0; i < 4; i++) dn_tdo[i] = dch[4*i + i];
  end

  // Behavioural reference model
  tap_state_e st_m;
  int         hold_m;
  logic [2:0] ir_m, irsr_m;
  logic [3:0] sel_m, selsr_m, idsr_m;
  logic       byp_m;

  function automatic tap_state_e step_tap(tap_state_e s, logic m);
    case (s)
      ST_TLR:                           return m ? ST_TLR : ST_RTI;
      ST_RTI, ST_UPD_DR, ST_UPD_IR:     return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR:                        return m ? ST_SEL_IR : ST_CAP_DR;
      ST_SEL_IR:                        return m ? ST_TLR : ST_CAP_IR;
      ST_CAP_DR, ST_SH_DR:              return m ? ST_EX1_DR : ST_SH_DR;
      ST_CAP_IR, ST_SH_IR:              return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_DR:                        return m ? ST_UPD_DR : ST_PAU_DR;
      ST_EX1_IR:                        return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_DR:                        return m ? ST_EX2_DR : ST_PAU_DR;
      ST_PAU_IR:                        return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_DR:                        return m ? ST_UPD_DR : ST_SH_DR;
      default:                          return m ? ST_UPD_IR : ST_SH_IR;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      hold_m <= 0; st_m <= ST_TLR; ir_m <= 3'b111; irsr_m <= '0;
      sel_m <= '0; selsr_m <= '0; idsr_m <= '0; byp_m <= 1'b0;
    end else if (hold_m < 2) begin
      hold_m <= hold_m + 1;
    end else begin
      case (st_m)
        ST_TLR:    begin ir_m <= 3'b111; sel_m <= '0; end
        ST_CAP_IR: irsr_m <= 3'b001;
        ST_SH_IR:  irsr_m <= {tdi, irsr_m[2:1]};
        ST_UPD_IR: ir_m <= irsr_m;
        ST_CAP_DR: begin
          if (ir_m == 3'b010)      selsr_m <= sel_m;
          else if (ir_m == 3'b011) idsr_m <= id_bus;
          else                     byp_m <= 1'b0;
        end
        ST_SH_DR: begin
          if (ir_m == 3'b010)      selsr_m <= {tdi, selsr_m[3:1]};
          else if (ir_m == 3'b011) idsr_m <= {tdi, idsr_m[3:1]};
          else                     byp_m <= tdi;
        end
        ST_UPD_DR: if (ir_m == 3'b010) sel_m <= selsr_m;
        default: ;
      endcase
      st_m <= step_tap(st_m, tms);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare after each falling edge, away from both clock edges
  always @(negedge tck) begin
    #2;
    if (!done) begin
      logic       own, link;
      logic       exp_oe;
      logic [3:0] exp_tdi;
      string      tag;
      exp_oe = (st_m == ST_SH_IR) || (st_m == ST_SH_DR);
      own = 1'b0;
      tag = "R4";
      if (st_m == ST_SH_IR) begin own = irsr_m[0]; tag = "R3"; end
      else if (st_m == ST_SH_DR) begin
        if (ir_m == 3'b010)      begin own = selsr_m[0]; tag = "R5"; end
        else if (ir_m == 3'b011) begin own = idsr_m[0];  tag = "R8"; end
        else                     begin own = byp_m;      tag = "R4 R3"; end
      end
      if (sel_m != 0) tag = {tag, " R6 R7"};
      link = own;
      for (int i = 0; i < 4; i++) begin
        exp_tdi[i] = link;
        if (sel_m[i]) link = dn_tdo[i];
      end
      chk(tdo_oe === exp_oe, "R1 R9 tdo_oe", {31'd0, tdo_oe}, {31'd0, exp_oe});
      if (exp_oe) begin
        chk(tdo === link, {tag, " tdo"}, {31'd0, tdo}, {31'd0, link});
        chk(dn_tdi === exp_tdi, "R6 R7 dn_tdi", {28'd0, dn_tdi}, {28'd0, exp_tdi});
      end
      chk(dn_tms === ({4{tms}} & sel_m), (st_m == ST_TLR) ? "R2 R10 dn_tms" : "R10 dn_tms",
          {28'd0, dn_tms}, {28'd0, {4{tms}} & sel_m});
      chk(dn_tck === tck, "R10 dn_tck", {31'd0, dn_tck}, {31'd0, tck});
    end
  end

  task automatic step(input logic m, input logic d);
    @(posedge tck); #2; tms = m; tdi = d;
  endtask

  task automatic load_ir(input logic [2:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 3; k++) step(k == 2, code[k]);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [31:0] data, input int n, input bit pause);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1 || (pause && k == n / 2), data[k]);
      if (pause && k == n / 2 && k != n - 1) begin
        step(0, 0); step(0, 0); step(1, 0); step(0, 0);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic select_paths(input logic [3:0] v);
    load_ir(3'b010);
    scan_dr({28'd0, v}, 4, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 trst_n = 1'b0;
    repeat (3) @(posedge tck);
    #2 trst_n = 1'b1;
    @(negedge tck); #3;
    chk(tdo_oe === 1'b0, "R2 reset tdo_oe", {31'd0, tdo_oe}, 32'd0);
    chk(dn_tms === 4'd0, "R2 reset dn_tms", {28'd0, dn_tms}, 32'd0);
    step(0, 0); step(0, 0); step(0, 0);

    // R4: bypass after reset
    scan_dr(32'hA5C3_9617, 10, 0);
    // R8: identification capture with two bus values
    id_bus = 4'b1010;
    load_ir(3'b011);
    scan_dr(32'h0000_0035, 6, 0);
    id_bus = 4'b0101;
    scan_dr(32'h0000_00F0, 8, 1);
    // R3: unknown code behaves as bypass
    load_ir(3'b000);
    scan_dr(32'h0000_0B6D, 12, 0);
    // R5 R6 R7: several selection subsets
    begin
      logic [3:0] pats [6] = '{4'b0001, 4'b1010, 4'b1111, 4'b0110, 4'b1000, 4'b0000};
      for (int p = 0; p < 6; p++) begin
        select_paths(pats[p]);
        scan_dr(32'h0000_0000 | (32'h5 << p), 4, 0);
        load_ir(3'b111);
        scan_dr(32'h9E3C_6B1D ^ (32'h1 << p), 16, 0);
        load_ir(3'b011);
        scan_dr(32'h0000_1234, 14, 1);
      end
    end
    // R2: five tms-high cycles from a live selection
    select_paths(4'b1101);
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(0, 0); step(0, 0);
    scan_dr(32'h0000_03C5, 10, 0);
    // R2: asynchronous reset mid-operation
    select_paths(4'b0111);
    step(1, 0); step(0, 0);
    @(posedge tck); #1 trst_n = 1'b0;
    repeat (2) @(posedge tck);
    #2 trst_n = 1'b1;
    step(0, 0); step(0, 0); step(0, 0);
    scan_dr(32'h0000_00A9, 8, 0);
    load_ir(3'b010);
    scan_dr(32'h0000_000E, 4, 0);
    repeat (4) step(0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule